// File: doc/BRIEF.md
# Frame Sync Search and Raw Symbol Receiver

This block runs two receive tasks on a stream of already-decided 2-bit symbol codes. A control processor writes a command, and the block carries it out on the symbol stream. It then raises a buffer-free flag and an interrupt flag so that the processor can take the result and write the next command.

The search task slides a window over the last 24 symbols it has accepted. It compares that window with a fixed frame-sync pattern, given as a parameter. The task ends at the first window whose count of differing symbols is no greater than a 2-bit tolerance. The raw-read task takes the next four symbols and packs them, with no reordering and no error correction, into one byte of the data buffer. A raw read may be written straight after a successful search, to capture the bytes that follow the sync word.

Symbols enter on a valid/ready stream. The block holds `sym_ready` high only while a task is running and no command write is under way. A symbol moves across only on a clock edge where both `sym_valid` and `sym_ready` are high. Between tasks the block applies back-pressure, and the upstream source must hold or discard its symbols. Commands, the tolerance, the result byte and the status flags are plain signals.

Top module: `fsync_raw_rx`

## Requirements
- R1: After reset, `buf_free` is 1, `irq` is 0, `rx_byte` is 0 and `sym_ready` is 0.
- R2: The command code is taken from `cmd_op` on an edge where `cmd_wr` is high. Code 2'b01 starts a search and code 2'b10 starts a raw read; each of them clears both `buf_free` and `irq`. Codes 2'b00 and 2'b11 abort any task: the block goes idle with `buf_free` at 1 and `irq` at 0. All changes are seen after that edge.
- R3: The search window holds only symbols accepted since the latest search command. No match is possible until 24 such symbols have been accepted. The oldest symbol in the window is compared with pattern symbol 0, which is the most significant dibit of the `SYNC_PAT` parameter.
- R4: A match is declared on the edge that accepts a symbol completing a window whose mismatch count is at most `tol` (0 to 3). On that edge `buf_free` and `irq` both become 1.
- R5: Mismatches are counted per symbol. A symbol that differs from the pattern in both bits counts as one mismatch.
- R6: The search stops at the first match. The block goes idle, `sym_ready` stays low, and no further symbol is consumed until the next command.
- R7: A raw read accepts four symbols. The first goes to `rx_byte[7:6]` and the last to `rx_byte[1:0]`. `rx_byte` is updated, and `buf_free` and `irq` become 1, on the edge that accepts the fourth symbol. Otherwise `rx_byte` holds its value.
- R8: `sym_ready` is high only while a task runs and `cmd_wr` is low. A valid symbol offered while `sym_ready` is low is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_valid | input | 1 | Symbol stream valid |
| sym_data | input | 2 | Decided symbol code |
| sym_ready | output | 1 | Symbol stream ready |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_op | input | 2 | Command code |
| tol | input | 2 | Sync tolerance in mismatched symbols |
| rx_byte | output | 8 | Data buffer byte from the raw read |
| buf_free | output | 1 | Buffer free, next command may be written |
| irq | output | 1 | Task-complete interrupt |

## Verification
A corrupted search window or fill count shows up at the ports as `buf_free` and `irq` rising one symbol too early or too late, or not rising at all. The bench compares both flags against its own sliding-window model after every accepted symbol, so a fault of this kind is seen within one symbol. A wrong packing counter or shift order shows as a wrong `rx_byte`, or as flags rising before or after the fourth symbol. A state register that stays busy shows as `sym_ready` high when the block should be idle, and symbols consumed at that point would be missing from the next raw byte.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int SYM_W = 2;

  typedef enum logic [1:0] {
    OP_HALT0  = 2'b00,
    OP_SEARCH = 2'b01,
    OP_READ4  = 2'b10,
    OP_HALT3  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_SEARCH = 2'b01,
    ST_READ   = 2'b10
  } st_e;
endpackage

// File: rtl/fsr_sym_window.sv
module fsr_sym_window #(
  parameter int LEN   = 24,
  parameter int SYM_W = 2,
  localparam int WIN_W = LEN * SYM_W,
  localparam int CNT_W = $clog2(LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift,
  input  logic [SYM_W-1:0] sym_in,
  output logic [WIN_W-1:0] win_next,
  output logic             full_next
);
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] fill_q;
  logic [CNT_W-1:0] fill_next;

  always_comb begin
    win_next  = shift ? {win_q[WIN_W-SYM_W-1:0], sym_in} : win_q;
    fill_next = (shift && (fill_q < CNT_W'(LEN))) ? fill_q + 1'b1 : fill_q;
    full_next = (fill_next == CNT_W'(LEN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (clear) begin
      win_q  <= '0;
      fill_q <= '0;
    end else begin
      win_q  <= win_next;
      fill_q <= fill_next;
    end
  end
endmodule

// File: rtl/fsr_mismatch.sv
module fsr_mismatch #(
  parameter int LEN   = 24,
  parameter int SYM_W = 2,
  parameter logic [LEN*SYM_W-1:0] PAT = '0,
  localparam int CNT_W = $clog2(LEN + 1)
) (
  input  logic [LEN*SYM_W-1:0] win,
  output logic [CNT_W-1:0]     miss
);
  logic [LEN-1:0] differs;

  // one flag per symbol position: a symbol differing in any bit counts once
  for (genvar j = 0; j < LEN; j++) begin : g_sym
    assign differs[j] = (win[j*SYM_W +: SYM_W] != PAT[j*SYM_W +: SYM_W]);
  end

  always_comb begin
    miss = '0;
    for (int j = 0; j < LEN; j++) begin
      miss = miss + CNT_W'(differs[j]);
    end
  end
endmodule

// File: rtl/fsr_raw_pack.sv
module fsr_raw_pack #(
  parameter int NSYM  = 4,
  parameter int SYM_W = 2,
  localparam int BYTE_W = NSYM * SYM_W,
  localparam int IDX_W  = (NSYM > 1) ? $clog2(NSYM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift,
  input  logic [SYM_W-1:0]  sym_in,
  output logic [BYTE_W-1:0] byte_next,
  output logic              last
);
  logic [BYTE_W-1:0] acc_q;
  logic [IDX_W-1:0]  idx_q;

  always_comb begin
    byte_next = {acc_q[BYTE_W-SYM_W-1:0], sym_in};
    last      = shift && (idx_q == IDX_W'(NSYM - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (clear || last) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (shift) begin
      acc_q <= byte_next;
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/fsync_raw_rx.sv
module fsync_raw_rx
  import fsr_pkg::*;
#(
  parameter int SYNC_LEN  = 24,
  parameter int RAW_SYMS  = 4,
  parameter int TOL_W     = 2,
  parameter logic [SYNC_LEN*SYM_W-1:0] SYNC_PAT = 48'hB5F2_3C9A_6E17,
  localparam int BYTE_W = RAW_SYMS * SYM_W,
  localparam int WIN_W  = SYNC_LEN * SYM_W,
  localparam int CNT_W  = $clog2(SYNC_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_valid,
  input  logic [SYM_W-1:0]  sym_data,
  output logic              sym_ready,
  input  logic              cmd_wr,
  input  logic [1:0]        cmd_op,
  input  logic [TOL_W-1:0]  tol,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              buf_free,
  output logic              irq
);
  st_e               st_q;
  logic              take;
  logic              win_shift;
  logic              pack_shift;
  logic [WIN_W-1:0]  win_next;
  logic              win_full;
  logic [CNT_W-1:0]  miss;
  logic              hit;
  logic [BYTE_W-1:0] byte_next;
  logic              pack_last;

  assign sym_ready  = (st_q != ST_IDLE) && !cmd_wr;
  assign take       = sym_valid && sym_ready;
  assign win_shift  = take && (st_q == ST_SEARCH);
  assign pack_shift = take && (st_q == ST_READ);

  fsr_sym_window #(.LEN(SYNC_LEN), .SYM_W(SYM_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cmd_wr),
    .shift    (win_shift),
    .sym_in   (sym_data),
    .win_next (win_next),
    .full_next(win_full)
  );

  fsr_mismatch #(.LEN(SYNC_LEN), .SYM_W(SYM_W), .PAT(SYNC_PAT)) u_cmp (
    .win (win_next),
    .miss(miss)
  );

  fsr_raw_pack #(.NSYM(RAW_SYMS), .SYM_W(SYM_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cmd_wr),
    .shift    (pack_shift),
    .sym_in   (sym_data),
    .byte_next(byte_next),
    .last     (pack_last)
  );

  assign hit = win_shift && win_full && (miss <= CNT_W'(tol));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      buf_free <= 1'b1;
      irq      <= 1'b0;
      rx_byte  <= '0;
    end else if (cmd_wr) begin
      irq <= 1'b0;
      case (op_e'(cmd_op))
        OP_SEARCH: begin st_q <= ST_SEARCH; buf_free <= 1'b0; end
        OP_READ4:  begin st_q <= ST_READ;   buf_free <= 1'b0; end
        default:   begin st_q <= ST_IDLE;   buf_free <= 1'b1; end
      endcase
    end else if (hit) begin
      st_q     <= ST_IDLE;
      buf_free <= 1'b1;
      irq      <= 1'b1;
    end else if (pack_last) begin
      st_q     <= ST_IDLE;
      rx_byte  <= byte_next;
      buf_free <= 1'b1;
      irq      <= 1'b1;
    end
  end
endmodule

// File: rtl/fsync_raw_rx_chk.sv
module fsync_raw_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sym_ready,
  input logic       cmd_wr,
  input logic [1:0] cmd_op,
  input logic [7:0] rx_byte,
  input logic       buf_free,
  input logic       irq
);
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (cmd_op == 2'b01 || cmd_op == 2'b10)) |=> (!buf_free && !irq));

  p_halt_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (cmd_op == 2'b00 || cmd_op == 2'b11)) |=> (buf_free && !irq && !sym_ready));

  p_irq_with_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> buf_free);

  p_stop_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !sym_ready);

  p_byte_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> $rose(irq));

  p_no_ready_on_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> !sym_ready);

  p_no_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_free |-> !sym_ready);
endmodule

bind fsync_raw_rx fsync_raw_rx_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .sym_ready(sym_ready),
  .cmd_wr   (cmd_wr),
  .cmd_op   (cmd_op),
  .rx_byte  (rx_byte),
  .buf_free (buf_free),
  .irq      (irq)
);

// File: tb/fsync_raw_rx_tb_top.sv
`timescale 1ns/1ps
module fsync_raw_rx_tb_top;
  localparam logic [47:0] PAT = 48'hB5F2_3C9A_6E17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0;
  logic [1:0] sym_data = '0;
  logic       sym_ready;
  logic       cmd_wr = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [1:0] tol = '0;
  logic [7:0] rx_byte;
  logic       buf_free;
  logic       irq;

  int checks = 0;
  int errors = 0;
  logic [1:0] stim [64];
  bit last_hit;

  always #2 clk = ~clk;

  fsync_raw_rx dut_i (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_data(sym_data),
    .sym_ready(sym_ready), .cmd_wr(cmd_wr), .cmd_op(cmd_op), .tol(tol),
    .rx_byte(rx_byte), .buf_free(buf_free), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] pat_sym(input int k);
    return PAT[2*(23-k) +: 2];
  endfunction

  function automatic int count_mis(input logic [47:0] w);
    int c = 0;
    for (int j = 0; j < 24; j++) if (w[2*j +: 2] != PAT[2*j +: 2]) c++;
    return c;
  endfunction

  task automatic issue(input logic [1:0] op);
    @(negedge clk); cmd_wr = 1'b1; cmd_op = op;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic send_sym(input logic [1:0] s);
    @(negedge clk); sym_valid = 1'b1; sym_data = s;
    @(posedge clk);
    @(negedge clk); sym_valid = 1'b0;
  endtask

  // R3 R4: bench model of the sliding window, flags checked after every symbol
  task automatic drive_search(input int n, input logic [1:0] t);
    logic [47:0] w = '0;
    int fill = 0;
    bit hit = 0;
    tol = t;
    issue(2'b01);
    chk("R2 search clears buf_free", buf_free, 0);
    for (int i = 0; i < n && !hit; i++) begin
      send_sym(stim[i]);
      w = {w[45:0], stim[i]};
      if (fill < 24) fill++;
      if (fill == 24 && count_mis(w) <= int'(t)) hit = 1;
      chk("R4 buf_free per symbol", buf_free, hit);
      chk("R4 irq per symbol", irq, hit);
    end
    last_hit = hit;
  endtask

  task automatic load_pattern(input int off);
    for (int k = 0; k < 24; k++) stim[off+k] = pat_sym(k);
  endtask

  task automatic t_reset;
    chk("R1 buf_free", buf_free, 1);
    chk("R1 irq", irq, 0);
    chk("R1 rx_byte", rx_byte, 0);
    chk("R1 sym_ready", sym_ready, 0);
  endtask

  task automatic t_exact;
    load_pattern(0);
    drive_search(24, 2'd0);
    chk("R4 exact pattern matches", last_hit, 1);
  endtask

  task automatic t_junk_prefix;
    for (int k = 0; k < 5; k++) stim[k] = 2'b00;
    load_pattern(5);
    drive_search(29, 2'd0);
    chk("R3 match after prefix", last_hit, 1);
  endtask

  task automatic t_per_symbol;
    load_pattern(0);
    stim[7] = stim[7] ^ 2'b11;
    drive_search(24, 2'd1);
    chk("R5 two-bit error counts once", last_hit, 1);
  endtask

  task automatic t_tol_edge;
    load_pattern(0);
    stim[1] ^= 2'b01; stim[9] ^= 2'b10; stim[17] ^= 2'b11;
    drive_search(24, 2'd3);
    chk("R4 three errors tol 3", last_hit, 1);
    load_pattern(0);
    stim[1] ^= 2'b01; stim[9] ^= 2'b10; stim[17] ^= 2'b11; stim[22] ^= 2'b01;
    drive_search(24, 2'd3);
    chk("R4 four errors tol 3", last_hit, 0);
    issue(2'b00);
    chk("R2 halt buf_free", buf_free, 1);
    chk("R2 halt irq", irq, 0);
    chk("R2 halt sym_ready", sym_ready, 0);
  endtask

  task automatic t_restart;
    tol = 2'd0;
    issue(2'b01);
    for (int k = 0; k < 20; k++) send_sym(pat_sym(k));
    for (int k = 0; k < 4; k++) stim[k] = pat_sym(20 + k);
    drive_search(4, 2'd0);
    chk("R3 window cleared by new search", buf_free, 0);
    issue(2'b11);
  endtask

  task automatic t_stop_then_read;
    load_pattern(0);
    drive_search(24, 2'd0);
    @(negedge clk); sym_valid = 1'b1; sym_data = 2'b00;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6 no ready after match", sym_ready, 0);
    end
    sym_valid = 1'b0;
    chk("R6 irq held", irq, 1);
    issue(2'b10);
    chk("R2 read clears irq", irq, 0);
    send_sym(2'b11); send_sym(2'b00); send_sym(2'b01);
    chk("R7 not done after three", buf_free, 0);
    send_sym(2'b10);
    chk("R7 byte packed", rx_byte, 8'hC6);
    chk("R7 irq on fourth", irq, 1);
  endtask

  task automatic t_read_hold;
    issue(2'b10);
    send_sym(2'b11); send_sym(2'b11); send_sym(2'b01);
    chk("R7 byte held mid-read", rx_byte, 8'hC6);
    chk("R7 irq low mid-read", irq, 0);
    send_sym(2'b01);
    chk("R7 second byte", rx_byte, 8'hF5);
  endtask

  task automatic t_cmd_ready;
    issue(2'b10);
    @(negedge clk); sym_valid = 1'b1; sym_data = 2'b11;
    #1 chk("R8 ready while busy", sym_ready, 1);
    cmd_wr = 1'b1; cmd_op = 2'b10;
    #1 chk("R8 no ready during cmd write", sym_ready, 0);
    @(negedge clk); cmd_wr = 1'b0; sym_valid = 1'b0;
    send_sym(2'b00); send_sym(2'b00); send_sym(2'b00);
    chk("R8 offered symbol not consumed", buf_free, 0);
    send_sym(2'b01);
    chk("R8 byte excludes refused symbol", rx_byte, 8'h01);
    issue(2'b10);
    send_sym(2'b10); send_sym(2'b10);
    issue(2'b11);
    chk("R2 abort keeps byte", rx_byte, 8'h01);
    chk("R2 abort frees buffer", buf_free, 1);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_junk_prefix();
    t_per_symbol();
    t_tol_edge();
    t_restart();
    t_stop_then_read();
    t_read_hold();
    t_cmd_ready();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule